// File: doc/BRIEF.md
# Low-speed serial packet receiver

This block receives one packet from a low-speed USB differential pair, sampled by a system clock that runs at a nominal eleven clocks per bit. A one-cycle `arm` pulse starts a packet attempt. The receiver first looks for the SYNC field and locks onto it. It then decodes the NRZI line coding and drops stuffed bits. Bits are gathered least significant first into bytes. Each finished byte is offered on a simple write port: a strobe, an address and the data byte. The port is meant for an external byte buffer of `BUF_BYTES` entries.

A phase tracker keeps the sampling point near the centre of each bit when the far transmitter runs up to about 1% fast or slow. A packet ends in one of three ways, and each raises its own one-cycle flag:
- normal end-of-packet, marked by single-ended zero on the pair;
- buffer overflow;
- no SYNC lock within a bounded time.

After any of these the receiver is idle until the next arm. The byte count of the last attempt stays on `byte_count` until then. CRC, PID and handshake handling belong to the logic that reads the buffer.

Top module: `usb_ls_rx`

## Requirements
- R1: After reset, `wr_en`, `eop`, `overflow` and `sync_err` are low and `byte_count` is 0.
- R2: Line states are decoded as follows:
  - J is `dp`=0, `dm`=1, and is also the idle state.
  - K is `dp`=1, `dm`=0.
  - SE0 is both lines at 0.
- R3: After `arm`, lock is taken only when a J-to-K edge is followed by K at two successive bit samples. If J is seen at the second sample, the receiver goes back to waiting for the next J-to-K edge.
- R4: If no lock is reached within `SYNC_TMO_CLKS` clocks of `arm`, `sync_err` pulses for one cycle and the receiver goes idle with nothing written.
- R5: Each data bit is 1 when `dm` at its sample equals `dm` at the previous sample, and 0 when it differs. The first data bit is compared with the final K of SYNC.
- R6: The bit after `STUFF_RUN` (6) consecutive 1 bits is discarded. That run includes the 1 formed by the final K K of SYNC. The run count restarts after every 0 bit and every discarded bit.
- R7: Bits are packed least significant bit first. Each completed byte produces `wr_en` high for exactly one cycle, with `wr_data` holding the byte. `wr_addr` counts 0, 1, 2 and so on within the packet.
- R8: SE0 at a bit sample ends the packet. It pulses `eop` for one cycle and discards any partly gathered byte. `byte_count` then equals the number of bytes written.
- R9: A byte that completes when `BUF_BYTES` (12) bytes have already been written is not written. Instead `overflow` pulses, the packet is abandoned without `eop`, and `byte_count` stays at `BUF_BYTES`.
- R10: Packets are decoded without error at bit periods of 11 clocks, 11 clocks +1% and 11 clocks −1%, including packets with long runs of 1 bits.
- R11: Line activity while the receiver is not armed produces no write and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, nominally 11 periods per bit |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| arm | input | 1 | One-cycle pulse that starts a packet attempt; honoured only when idle |
| dp | input | 1 | D+ line, asynchronous |
| dm | input | 1 | D- line, asynchronous |
| wr_en | output | 1 | Write strobe for one decoded byte |
| wr_addr | output | clog2(BUF_BYTES) | Byte index within the packet |
| wr_data | output | 8 | Decoded byte |
| eop | output | 1 | One-cycle pulse: packet ended by SE0 |
| overflow | output | 1 | One-cycle pulse: buffer full, packet abandoned |
| sync_err | output | 1 | One-cycle pulse: no SYNC lock in time |
| byte_count | output | clog2(BUF_BYTES+1) | Bytes written in the current or last packet |

## Verification
The embedded properties assume that `dp` and `dm` hold each line state for about one bit period, give or take a few percent. They also assume that an edge appears at least once every seven bits, which bit stuffing guarantees. Under those conditions, the strobes and flags stay isolated pulses, and the write address stays inside the buffer. The stimulus builds every waveform from whole bit periods of 11 clocks scaled by 0.99, 1.00 or 1.01, and applies stuffing to every generated stream. Glitches narrower than a bit and bit periods outside that band are therefore never produced.

// File: rtl/usb_ls_rx_pkg.sv
package usb_ls_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HUNT,
    ST_CHECK,
    ST_RECV
  } rx_state_e;

  typedef struct packed {
    logic dp;
    logic dm;
  } line_t;

  function automatic logic line_is_k(line_t l);
    return l.dp & ~l.dm;
  endfunction

  function automatic logic line_is_se0(line_t l);
    return ~l.dp & ~l.dm;
  endfunction

endpackage

// File: rtl/usb_rx_linesync.sv
module usb_rx_linesync
  import usb_ls_rx_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  dp_i,
  input  logic  dm_i,
  output line_t line_o
);

  logic [STAGES-1:0] dp_sr, dp_sr_n;
  logic [STAGES-1:0] dm_sr, dm_sr_n;

  generate
    if (STAGES == 1) begin : g_one
      always_comb begin
        dp_sr_n = dp_i;
        dm_sr_n = dm_i;
      end
    end else begin : g_many
      always_comb begin
        dp_sr_n = {dp_sr[STAGES-2:0], dp_i};
        dm_sr_n = {dm_sr[STAGES-2:0], dm_i};
      end
    end
  endgenerate

  // reset to the idle J state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_sr <= '0;
      dm_sr <= '1;
    end else begin
      dp_sr <= dp_sr_n;
      dm_sr <= dm_sr_n;
    end
  end

  assign line_o.dp = dp_sr[STAGES-1];
  assign line_o.dm = dm_sr[STAGES-1];

endmodule

// File: rtl/usb_rx_phase.sv
module usb_rx_phase #(
  parameter int CLKS_PER_BIT = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dm_s,
  output logic strobe,
  output logic edge_o
);

  localparam int PW = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [PW-1:0] CENTER = PW'((CLKS_PER_BIT - 1) / 2);
  localparam logic [PW-1:0] LAST   = PW'(CLKS_PER_BIT - 1);

  logic [PW-1:0] ph, ph_n;
  logic          dm_prev;

  assign edge_o = dm_s ^ dm_prev;
  assign strobe = (ph == CENTER);

  // every transition re-aligns the bit counter, so drift can only build
  // up over the at most seven bits between guaranteed edges
  always_comb begin
    if (edge_o)          ph_n = '0;
    else if (ph == LAST) ph_n = '0;
    else                 ph_n = ph + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= '0;
      dm_prev <= 1'b1;
    end else begin
      ph      <= ph_n;
      dm_prev <= dm_s;
    end
  end

  assert_strobe_gap_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);

endmodule

// File: rtl/usb_rx_deser.sv
module usb_rx_deser #(
  parameter int DATA_W    = 8,
  parameter int STUFF_RUN = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  input  logic              dm_bit,
  output logic              byte_vld,
  output logic [DATA_W-1:0] byte_q
);

  localparam int SW = $clog2(STUFF_RUN + 1);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BW-1:0] BIT_LAST = BW'(DATA_W - 1);
  localparam logic [SW-1:0] RUN_MAX  = SW'(STUFF_RUN);

  logic              last_dm, last_dm_n;
  logic [SW-1:0]     run, run_n;
  logic [BW-1:0]     bidx, bidx_n;
  logic [DATA_W-1:0] sh, sh_n;
  logic              vld_n;
  logic [DATA_W-1:0] q_n;
  logic              bit_v;

  always_comb begin
    last_dm_n = last_dm;
    run_n     = run;
    bidx_n    = bidx;
    sh_n      = sh;
    vld_n     = 1'b0;
    q_n       = byte_q;
    bit_v     = (dm_bit == last_dm);
    if (clr) begin
      last_dm_n = 1'b0;          // final SYNC bit is K (dm low)
      run_n     = SW'(1);        // final K K of SYNC is a 1 bit
      bidx_n    = '0;
      sh_n      = '0;
    end else if (take) begin
      last_dm_n = dm_bit;
      if (run == RUN_MAX) begin
        run_n = '0;              // stuffed bit, discarded
      end else begin
        sh_n   = {bit_v, sh[DATA_W-1:1]};
        run_n  = bit_v ? run + SW'(1) : '0;
        bidx_n = (bidx == BIT_LAST) ? '0 : bidx + BW'(1);
        if (bidx == BIT_LAST) begin
          vld_n = 1'b1;
          q_n   = sh_n;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_dm  <= 1'b1;
      run      <= '0;
      bidx     <= '0;
      sh       <= '0;
      byte_vld <= 1'b0;
      byte_q   <= '0;
    end else begin
      last_dm  <= last_dm_n;
      run      <= run_n;
      bidx     <= bidx_n;
      sh       <= sh_n;
      byte_vld <= vld_n;
      byte_q   <= q_n;
    end
  end

  assert_run_bound_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    run <= RUN_MAX);
  assert_byte_pulse_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld);

endmodule

// File: rtl/usb_ls_rx.sv
module usb_ls_rx
  import usb_ls_rx_pkg::*;
#(
  parameter int CLKS_PER_BIT  = 11,
  parameter int BUF_BYTES     = 12,
  parameter int SYNC_TMO_CLKS = 256,
  parameter int SYNC_STAGES   = 2,
  parameter int STUFF_RUN     = 6,
  localparam int AW = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1,
  localparam int CW = $clog2(BUF_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          dp,
  input  logic          dm,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          eop,
  output logic          overflow,
  output logic          sync_err,
  output logic [CW-1:0] byte_count
);

  localparam int TW = $clog2(SYNC_TMO_CLKS + 1);
  localparam logic [TW-1:0] TMO_LAST = TW'(SYNC_TMO_CLKS - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(BUF_BYTES);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_core_n <= rst_meta;
    end
  end

  line_t line_s;
  logic  strobe, edge_s;
  logic  des_clr, des_take, byte_vld;
  logic [7:0] byte_q;

  usb_rx_linesync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .dp_i(dp), .dm_i(dm), .line_o(line_s)
  );

  usb_rx_phase #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_phase (
    .clk(clk), .rst_n(rst_core_n), .dm_s(line_s.dm),
    .strobe(strobe), .edge_o(edge_s)
  );

  usb_rx_deser #(.DATA_W(8), .STUFF_RUN(STUFF_RUN)) u_deser (
    .clk(clk), .rst_n(rst_core_n), .clr(des_clr), .take(des_take),
    .dm_bit(line_s.dm), .byte_vld(byte_vld), .byte_q(byte_q)
  );

  rx_state_e     state, state_n;
  logic [TW-1:0] tmo, tmo_n;
  logic          chk2, chk2_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          eop_n, ovf_n, serr_n;
  logic          is_k, is_se0, full;

  assign is_k   = line_is_k(line_s);
  assign is_se0 = line_is_se0(line_s);
  assign full   = (cnt == CNT_FULL);

  assign des_take = (state == ST_RECV) && strobe && !is_se0;
  assign wr_en    = (state == ST_RECV) && byte_vld && !full;
  assign wr_data  = byte_q;
  assign wr_addr  = cnt[AW-1:0];
  assign byte_count = cnt;

  always_comb begin
    state_n = state;
    tmo_n   = tmo;
    chk2_n  = chk2;
    cnt_n   = cnt;
    eop_n   = 1'b0;
    ovf_n   = 1'b0;
    serr_n  = 1'b0;
    des_clr = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (arm) begin
          state_n = ST_HUNT;
          tmo_n   = '0;
          cnt_n   = '0;
          chk2_n  = 1'b0;
        end
      end
      ST_HUNT, ST_CHECK: begin
        tmo_n = tmo + TW'(1);
        if (tmo == TMO_LAST) begin
          serr_n  = 1'b1;
          state_n = ST_IDLE;
        end else if (state == ST_HUNT) begin
          if (edge_s && is_k) begin
            state_n = ST_CHECK;
            chk2_n  = 1'b0;
          end
        end else if (strobe) begin
          if (!is_k) begin
            state_n = ST_HUNT;
          end else if (chk2) begin
            state_n = ST_RECV;
            des_clr = 1'b1;
          end else begin
            chk2_n = 1'b1;
          end
        end
      end
      ST_RECV: begin
        if (strobe && is_se0) begin
          eop_n   = 1'b1;
          state_n = ST_IDLE;
        end else if (byte_vld) begin
          if (full) begin
            ovf_n   = 1'b1;
            state_n = ST_IDLE;
          end else begin
            cnt_n = cnt + CW'(1);
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state    <= ST_IDLE;
      tmo      <= '0;
      chk2     <= 1'b0;
      cnt      <= '0;
      eop      <= 1'b0;
      overflow <= 1'b0;
      sync_err <= 1'b0;
    end else begin
      state    <= state_n;
      tmo      <= tmo_n;
      chk2     <= chk2_n;
      cnt      <= cnt_n;
      eop      <= eop_n;
      overflow <= ovf_n;
      sync_err <= serr_n;
    end
  end

  assert_wr_addr_range_R7 : assert property (@(posedge clk) disable iff (!rst_core_n)
    wr_en |-> (wr_addr < AW'(BUF_BYTES)));
  assert_wr_single_R7 : assert property (@(posedge clk) disable iff (!rst_core_n)
    wr_en |=> !wr_en);
  assert_flags_exclusive_R8 : assert property (@(posedge clk) disable iff (!rst_core_n)
    $onehot0({eop, overflow, sync_err}));
  assert_eop_after_se0_R8 : assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(eop) |-> $past(is_se0));
  assert_count_bound_R9 : assert property (@(posedge clk) disable iff (!rst_core_n)
    byte_count <= CNT_FULL);
  assert_serr_from_hunt_R4 : assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(sync_err) |-> ($past(state) == ST_HUNT || $past(state) == ST_CHECK));

endmodule

// File: tb/sim_usb_ls_rx.sv
`timescale 1ns/1ps
module sim_usb_ls_rx;

  localparam real CLK_NS = 10.0;
  localparam int  BUF    = 12;

  logic       clk = 1'b0;
  logic       rst_n, arm, dp, dm;
  logic       wr_en, eop, overflow, sync_err;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic [3:0] byte_count;

  usb_ls_rx u0 (
    .clk(clk), .rst_n(rst_n), .arm(arm), .dp(dp), .dm(dm),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .eop(eop), .overflow(overflow), .sync_err(sync_err),
    .byte_count(byte_count)
  );

  always #(CLK_NS / 2.0) clk = ~clk;

  int nchk = 0, nfail = 0;
  int n_eop = 0, n_ovf = 0, n_serr = 0;
  logic [15:0] exp_q[$];
  logic [7:0]  pkt[0:15];
  bit lvl;   // 1 = K
  int ones;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (wr_en) begin
        if (exp_q.size() == 0) begin
          nchk++; nfail++;
          $display("FAIL R11 unexpected write: actual %0h expected none", {wr_addr, wr_data});
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk({4'h0, wr_addr, wr_data} == e, "R7", "write addr/data",
              {wr_addr, wr_data}, e);
        end
      end
      if (eop)      n_eop++;
      if (overflow) n_ovf++;
      if (sync_err) n_serr++;
    end
  end

  task automatic put(input bit k, input real t);
    dp = k; dm = !k; #(t);
  endtask

  task automatic tx_bit(input bit b, input real t);
    if (!b) lvl = !lvl;
    put(lvl, t);
    if (b) ones++; else ones = 0;
    if (ones == 6) begin
      lvl = !lvl; put(lvl, t); ones = 0;   // stuffed bit R6
    end
  endtask

  task automatic send_pkt(input int n, input int extra, input real bt, input bit expect_it);
    for (int i = 0; i < 3; i++) put(1'b0, bt);
    for (int i = 0; i < 8; i++) put((i % 2 == 0) || (i == 7), bt);  // K J K J K J K K
    lvl = 1'b1; ones = 1;
    for (int i = 0; i < n; i++) begin
      if (expect_it && i < BUF) exp_q.push_back({8'(i), pkt[i]});
      for (int b = 0; b < 8; b++) tx_bit(pkt[i][b], bt);
    end
    for (int j = 0; j < extra; j++) tx_bit(j % 2 == 0, bt);
    dp = 1'b0; dm = 1'b0; #(2.0 * bt);
    put(1'b0, 3.0 * bt);
  endtask

  task automatic do_arm();
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_sim();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 150000.0);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    int e0, o0, s0;
    rst_n = 1'b0; arm = 1'b0; dp = 1'b0; dm = 1'b1;
    wait_clks(5); rst_n = 1'b1; wait_clks(5);

    // R1 reset state
    chk(!wr_en && !eop && !overflow && !sync_err, "R1", "flags after reset",
        {wr_en, eop, overflow, sync_err}, 0);
    chk(byte_count == 0, "R1", "byte_count after reset", byte_count, 0);

    // R11 not armed: no write, no flag
    pkt[0] = 8'h11; pkt[1] = 8'h22; pkt[2] = 8'h33;
    e0 = n_eop; o0 = n_ovf; s0 = n_serr;
    send_pkt(3, 0, 110.0, 1'b0); wait_clks(30);
    chk(n_eop == e0 && n_ovf == o0 && n_serr == s0, "R11", "flags while idle",
        n_eop + n_ovf + n_serr, e0 + o0 + s0);

    // R2 R5 R6 R7 R8 nominal packet with a stuffing run
    pkt[0] = 8'hA5; pkt[1] = 8'hFF; pkt[2] = 8'h3F;
    e0 = n_eop; do_arm(); send_pkt(3, 0, 110.0, 1'b1); wait_clks(30);
    chk(exp_q.size() == 0, "R7", "all bytes written", exp_q.size(), 0);
    chk(n_eop == e0 + 1, "R8", "eop after SE0 (R2 encoding)", n_eop - e0, 1);
    chk(byte_count == 3, "R8", "byte_count", byte_count, 3);

    // R10 fast and slow transmitter, long 1 runs (R6) and all-zero byte (R5)
    pkt[0] = 8'h00; pkt[1] = 8'hFF; pkt[2] = 8'hFF; pkt[3] = 8'h7E;
    pkt[4] = 8'h80; pkt[5] = 8'h01; pkt[6] = 8'hC3; pkt[7] = 8'hFE;
    for (int r = 0; r < 2; r++) begin
      e0 = n_eop; do_arm();
      send_pkt(8, 0, (r == 0) ? 108.9 : 111.1, 1'b1); wait_clks(30);
      chk(exp_q.size() == 0, "R10", "bytes at off-nominal rate", exp_q.size(), 0);
      chk(n_eop == e0 + 1, "R10", "eop at off-nominal rate", n_eop - e0, 1);
      chk(byte_count == 8, "R10", "byte_count at off-nominal rate", byte_count, 8);
    end

    // R8 partial byte before SE0 is dropped
    pkt[0] = 8'h12; pkt[1] = 8'h34;
    e0 = n_eop; do_arm(); send_pkt(2, 3, 110.0, 1'b1); wait_clks(30);
    chk(exp_q.size() == 0, "R8", "bytes before partial", exp_q.size(), 0);
    chk(n_eop == e0 + 1, "R8", "eop with partial byte", n_eop - e0, 1);
    chk(byte_count == 2, "R8", "partial byte not counted", byte_count, 2);

    // R9 overflow
    for (int i = 0; i < 14; i++) pkt[i] = 8'(i * 17 + 3);
    e0 = n_eop; o0 = n_ovf; do_arm(); send_pkt(14, 0, 110.0, 1'b1); wait_clks(30);
    chk(exp_q.size() == 0, "R9", "buffer-size bytes written", exp_q.size(), 0);
    chk(n_ovf == o0 + 1, "R9", "overflow pulse", n_ovf - o0, 1);
    chk(n_eop == e0, "R9", "no eop after overflow", n_eop - e0, 0);
    chk(byte_count == BUF, "R9", "byte_count held at size", byte_count, BUF);

    // R4 timeout with idle line
    s0 = n_serr; do_arm(); wait_clks(400);
    chk(n_serr == s0 + 1, "R4", "sync_err on idle line", n_serr - s0, 1);
    chk(byte_count == 0, "R4", "nothing written", byte_count, 0);

    // R3 a lone K bit is not a lock
    s0 = n_serr; e0 = n_eop; do_arm();
    put(1'b0, 220.0); put(1'b1, 110.0); put(1'b0, 110.0 * 40.0);
    chk(n_serr == s0 + 1, "R3", "single K gives no lock", n_serr - s0, 1);
    chk(n_eop == e0 && exp_q.size() == 0, "R3", "no packet from single K", n_eop - e0, 0);

    finish_sim();
  end

endmodule